// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block sequences zero-overhead loops for a simple in-order core whose instructions are all four bytes long. A loop-start command carries two operands: an iteration count, and a body length measured in retired instructions. When the command is accepted, the block pushes a loop context onto a small stack, so loops can nest. On each retired instruction the block advances only the innermost context. When that context reaches the last instruction of its body, the block does one of two things. If iterations remain, it redirects the program counter back to the first body instruction. On the final pass, it discards the context and execution falls through.

The core must drive the loop-start command in the cycle in which the loop-start instruction itself retires. That instruction is not part of the body. The first body instruction sits four bytes above it. The redirect leaves the block as a registered pulse together with its target address. Two error flags report problems and stay set until reset: one for a push onto a full stack, and one for a command with a zero operand.

Top module: `loop_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `redir_o`, `err_ovf_o` and `err_arg_o` are 0 and the context stack is empty. Reset also clears both error flags.
- R2: A cycle with `start_i` high and both operands non-zero pushes a context. The retirement in that cycle is the loop-start instruction and is not counted. The next retirement is body instruction 0.
- R3: Only the most recently pushed context advances on a retirement (`retire_i` high, `start_i` low). Outer contexts keep their position until the inner one is discarded. The retirement that ends the inner loop does not advance the outer context.
- R4: When body instruction `body-1` retires at PC `p` and at least one further iteration remains, the block redirects to `p - (body-1)*4`. The next retirement is body instruction 0 of the next iteration.
- R5: When body instruction `body-1` of the final iteration retires, the context is discarded and no redirect is produced. The same applies when the iteration count is 1.
- R6: A valid loop-start while the stack already holds `DEPTH` contexts sets `err_ovf_o` and leaves the stack unchanged. `err_ovf_o` stays 1 until reset.
- R7: A loop-start with a zero iteration count or a zero body length sets `err_arg_o` and pushes nothing. `err_arg_o` stays 1 until reset.
- R8: `redir_o` is a register. It is 1 for exactly the one cycle after the clock edge at which the loop-back retirement was sampled, and `redir_pc_o` carries the target in that cycle. Retirements while the stack is empty never redirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Loop-start instruction retires this cycle |
| iter_i | input | 16 | Iteration count of the loop-start |
| body_i | input | 10 | Body length in instructions |
| pc_i | input | PC_W (32) | PC of the instruction retiring this cycle |
| retire_i | input | 1 | An instruction retires this cycle |
| redir_o | output | 1 | One-cycle PC redirect request |
| redir_pc_o | output | PC_W (32) | Redirect target address |
| err_ovf_o | output | 1 | Sticky stack-overflow flag |
| err_arg_o | output | 1 | Sticky zero-operand flag |

## Verification
The hardest situation to reach is a full stack. It takes eight accepted loop-starts in a row, with no retirement in between, before the ninth push can be refused. The stimulus pushes eight loops, sends a ninth with an iteration count of 1, and then retires one instruction. That retirement must still loop back to the eighth loop's body, which shows that the refused context never reached the top. Nesting is exercised by a trace in which the inner loop ends before the outer body does, so the frozen outer count becomes visible in the outer redirect.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  localparam int ITER_W = 16;
  localparam int BODY_W = 10;

  typedef struct packed {
    logic [ITER_W-1:0] iter_tot;  // iterations requested
    logic [ITER_W-1:0] iter_idx;  // iterations completed so far
    logic [BODY_W-1:0] body_len;  // body length in instructions
    logic [BODY_W-1:0] instr_idx; // index of next body instruction
  } loop_ctx_t;
endpackage

// File: rtl/loop_ctx_stack.sv
module loop_ctx_stack
  import loop_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  loop_ctx_t        push_ctx_i,
  input  logic             pop_i,
  input  logic             upd_i,
  input  loop_ctx_t        upd_ctx_i,
  output loop_ctx_t        top_ctx_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o,
  output logic             full_o
);
  loop_ctx_t        ctx_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = empty_o ? '0 : IDX_W'(cnt_q - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !full_o)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop_i && !empty_o) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic      wr_push, wr_upd, slot_en;
    loop_ctx_t slot_d;
    assign wr_push = push_i && !full_o && (cnt_q == CNT_W'(g));
    assign wr_upd  = upd_i && !empty_o && (top_idx == IDX_W'(g));
    assign slot_en = wr_push || wr_upd;
    assign slot_d  = wr_push ? push_ctx_i : upd_ctx_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctx_q[g] <= '0;
      else if (slot_en) ctx_q[g] <= slot_d;
    end
  end

  assign top_ctx_o = empty_o ? '0 : ctx_q[top_idx];
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/loop_step.sv
module loop_step
  import loop_seq_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            active_i,
  input  logic            advance_i,
  input  loop_ctx_t       ctx_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            pop_o,
  output logic            upd_o,
  output loop_ctx_t       ctx_o,
  output logic            redir_o,
  output logic [PC_W-1:0] tgt_o
);
  logic body_end, last_iter, step;

  assign step      = active_i && advance_i;
  assign body_end  = (ctx_i.instr_idx == ctx_i.body_len - BODY_W'(1));
  assign last_iter = (ctx_i.iter_idx == ctx_i.iter_tot - ITER_W'(1));

  always_comb begin
    ctx_o   = ctx_i;
    pop_o   = 1'b0;
    upd_o   = 1'b0;
    redir_o = 1'b0;
    tgt_o   = pc_i - (PC_W'(ctx_i.body_len - BODY_W'(1)) << 2);
    if (step) begin
      if (body_end && last_iter) begin
        pop_o = 1'b1;
      end else if (body_end) begin
        upd_o           = 1'b1;
        redir_o         = 1'b1;
        ctx_o.iter_idx  = ctx_i.iter_idx + ITER_W'(1);
        ctx_o.instr_idx = '0;
      end else begin
        upd_o           = 1'b1;
        ctx_o.instr_idx = ctx_i.instr_idx + BODY_W'(1);
      end
    end
  end
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ITER_W-1:0] iter_i,
  input  logic [BODY_W-1:0] body_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              retire_i,
  output logic              redir_o,
  output logic [PC_W-1:0]   redir_pc_o,
  output logic              err_ovf_o,
  output logic              err_arg_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             args_ok, push, advance, stk_empty, stk_full;
  logic             pop, upd, redir_d, ovf_d, arg_d;
  logic [PC_W-1:0]  tgt_d, tgt_q;
  logic             redir_q, ovf_q, arg_q;
  logic [CNT_W-1:0] depth_w;
  loop_ctx_t        top_ctx, new_ctx, upd_ctx;

  assign args_ok = (iter_i != '0) && (body_i != '0);
  assign push    = start_i && args_ok;
  assign advance = retire_i && !start_i;

  always_comb begin
    new_ctx           = '0;
    new_ctx.iter_tot  = iter_i;
    new_ctx.body_len  = body_i;
  end

  loop_ctx_stack #(.DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push),
    .push_ctx_i(new_ctx),
    .pop_i     (pop),
    .upd_i     (upd),
    .upd_ctx_i (upd_ctx),
    .top_ctx_o (top_ctx),
    .cnt_o     (depth_w),
    .empty_o   (stk_empty),
    .full_o    (stk_full)
  );

  loop_step #(.PC_W(PC_W)) u_step (
    .active_i (!stk_empty),
    .advance_i(advance),
    .ctx_i    (top_ctx),
    .pc_i     (pc_i),
    .pop_o    (pop),
    .upd_o    (upd),
    .ctx_o    (upd_ctx),
    .redir_o  (redir_d),
    .tgt_o    (tgt_d)
  );

  always_comb begin
    ovf_d = ovf_q || (push && stk_full);
    arg_d = arg_q || (start_i && !args_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= 1'b0;
      ovf_q   <= 1'b0;
      arg_q   <= 1'b0;
    end else begin
      redir_q <= redir_d;
      ovf_q   <= ovf_d;
      arg_q   <= arg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgt_q <= '0;
    else if (redir_d) tgt_q <= tgt_d;
  end

  assign redir_o    = redir_q;
  assign redir_pc_o = tgt_q;
  assign err_ovf_o  = ovf_q;
  assign err_arg_o  = arg_q;
endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             args_ok,
  input logic             retire_i,
  input logic             redir_o,
  input logic             err_ovf_o,
  input logic             err_arg_o,
  input logic [CNT_W-1:0] depth_w
);
  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_w <= CNT_W'(DEPTH));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf_o |=> err_ovf_o);

  a_r6_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && args_ok && depth_w == CNT_W'(DEPTH)) |=> (err_ovf_o && $stable(depth_w)));

  a_r7_arg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_arg_o |=> err_arg_o);

  a_r7_bad_args: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !args_ok) |=> (err_arg_o && $stable(depth_w)));

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && args_ok && depth_w != CNT_W'(DEPTH)) |=> depth_w == $past(depth_w) + CNT_W'(1));

  a_r8_empty_no_redir: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_w == '0) |=> !redir_o);

  a_r8_redir_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i || start_i) |=> !redir_o);
endmodule

bind loop_seq loop_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .args_ok  (args_ok),
  .retire_i (retire_i),
  .redir_o  (redir_o),
  .err_ovf_o(err_ovf_o),
  .err_arg_o(err_arg_o),
  .depth_w  (depth_w)
);

// File: tb/tb_loop_seq.sv
module tb_loop_seq;
  logic        clk, rst_n, start_i, retire_i;
  logic [15:0] iter_i;
  logic [9:0]  body_i;
  logic [31:0] pc_i;
  logic        redir_o, err_ovf_o, err_arg_o;
  logic [31:0] redir_pc_o;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  loop_seq dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        st; logic [15:0] it; logic [9:0] bd;
    logic [31:0] pc; logic rt; logic ex; logic [31:0] tg;
  } vec_t;

  // R2 R4 R5: single loop; R3: nested; R8: start priority over retire
  localparam vec_t VEC [21] = '{
    '{1'b1,16'd3,10'd2,32'h100,1'b0,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h104,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h108,1'b1,1'b1,32'h104},
    '{1'b0,16'd0,10'd0,32'h104,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h108,1'b1,1'b1,32'h104},
    '{1'b0,16'd0,10'd0,32'h104,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h108,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h10C,1'b1,1'b0,32'h0},
    '{1'b1,16'd2,10'd2,32'h200,1'b0,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h204,1'b1,1'b0,32'h0},
    '{1'b1,16'd2,10'd1,32'h208,1'b0,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h20C,1'b1,1'b1,32'h20C},
    '{1'b0,16'd0,10'd0,32'h20C,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h210,1'b1,1'b1,32'h20C},
    '{1'b0,16'd0,10'd0,32'h20C,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h210,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h214,1'b1,1'b0,32'h0},
    '{1'b1,16'd2,10'd1,32'h300,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h304,1'b1,1'b1,32'h304},
    '{1'b0,16'd0,10'd0,32'h304,1'b1,1'b0,32'h0},
    '{1'b0,16'd0,10'd0,32'h308,1'b0,1'b0,32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic cyc(input logic st, input logic [15:0] it, input logic [9:0] bd,
                     input logic [31:0] pc, input logic rt);
    @(negedge clk);
    start_i = st; iter_i = it; body_i = bd; pc_i = pc; retire_i = rt;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 0; retire_i = 0; iter_i = 0; body_i = 0; pc_i = 0;
    #1;
    chk("R1 redir in reset", {31'b0, redir_o}, 32'd0);
    chk("R1 ovf in reset", {31'b0, err_ovf_o}, 32'd0);
    chk("R1 arg in reset", {31'b0, err_arg_o}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    do_reset();
    cyc(0, 0, 0, 32'h0, 0);
    chk("R1 redir after reset", {31'b0, redir_o}, 32'd0);
    // R8: retirements with empty stack never redirect
    cyc(0, 0, 0, 32'h40, 1);
    chk("R8 empty stack retire", {31'b0, redir_o}, 32'd0);

    foreach (VEC[i]) begin
      cyc(VEC[i].st, VEC[i].it, VEC[i].bd, VEC[i].pc, VEC[i].rt);
      chk($sformatf("R2 R3 R4 R5 R8 vec %0d redir", i), {31'b0, redir_o}, {31'b0, VEC[i].ex});
      if (VEC[i].ex)
        chk($sformatf("R4 vec %0d target", i), redir_pc_o, VEC[i].tg);
    end
    // R8: pulse lasts one cycle
    cyc(1, 16'd3, 10'd1, 32'h500, 0);
    cyc(0, 0, 0, 32'h504, 1);
    chk("R8 pulse high", {31'b0, redir_o}, 32'd1);
    cyc(0, 0, 0, 32'h504, 0);
    chk("R8 pulse drops", {31'b0, redir_o}, 32'd0);
    chk("R6 no ovf yet", {31'b0, err_ovf_o}, 32'd0);

    // R7: zero operands rejected, nothing pushed
    do_reset();
    cyc(1, 16'd0, 10'd2, 32'h600, 0);
    chk("R7 zero iter flag", {31'b0, err_arg_o}, 32'd1);
    cyc(0, 0, 0, 32'h604, 1);
    cyc(0, 0, 0, 32'h608, 1);
    chk("R7 nothing pushed", {31'b0, redir_o}, 32'd0);
    cyc(1, 16'd2, 10'd0, 32'h700, 0);
    cyc(0, 0, 0, 32'h704, 1);
    chk("R7 zero body not pushed", {31'b0, redir_o}, 32'd0);
    chk("R7 flag sticky", {31'b0, err_arg_o}, 32'd1);

    // R6: overflow
    do_reset();
    chk("R1 arg cleared by reset", {31'b0, err_arg_o}, 32'd0);
    for (int k = 0; k < 8; k++) cyc(1, 16'd2, 10'd1, 32'h400, 0);
    chk("R6 full no flag", {31'b0, err_ovf_o}, 32'd0);
    cyc(1, 16'd1, 10'd1, 32'h800, 0);
    chk("R6 overflow flag", {31'b0, err_ovf_o}, 32'd1);
    cyc(0, 0, 0, 32'h404, 1);
    chk("R6 stack unchanged redir", {31'b0, redir_o}, 32'd1);
    chk("R6 stack unchanged target", redir_pc_o, 32'h404);
    cyc(0, 0, 0, 32'h404, 0);
    chk("R6 flag sticky", {31'b0, err_ovf_o}, 32'd1);
    do_reset();
    chk("R1 ovf cleared by reset", {31'b0, err_ovf_o}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule